// File: doc/BRIEF.md
# Interrupt Vector and Save/Restore Unit

This unit is the architectural side of interrupt entry and exit in a processor core. When an interrupt is granted, it stores the return address and the machine state word into a save/restore pair. Critical-class interrupts use one pair and all other interrupts use the other, so a critical interrupt that arrives during a noncritical handler leaves that handler's return state intact. In the same cycle it presents the handler address. The handler address is the upper half of a vector base register followed by an offset, aligned to 16 bytes, taken from a per-type offset register. Depending on the interrupt type, it also records the syndrome bits and the faulting data address.

Two request lanes come in: one for critical-class types and one for noncritical-class types. The critical lane always wins. A noncritical request that loses is simply not acknowledged, and it stays pending for as long as the requester holds it. Two strobes return from the two interrupt classes. Each one presents the saved address as the redirect target and presents the saved state word for restoring. Every register in the unit can also be read and written through a special-register port.

Top module: `intr_vector_unit`

## Requirements
- R1: When `irq_ack` is high, on the next clock save register 0 (SPR 0) holds `cur_pc` and save register 1 (SPR 1) holds `cur_msr`. The critical pair (SPR 2, SPR 3) keeps its value.
- R2: When `cirq_ack` is high, on the next clock critical register 0 (SPR 2) holds `cur_pc` and critical register 1 (SPR 3) holds `cur_msr`. The noncritical pair (SPR 0, SPR 1) keeps its value.
- R3: `cirq_ack` equals `cirq_req`. `irq_ack` is high only when `irq_req` is high and `cirq_req` is low. The two acks are never high together.
- R4: In a cycle with an ack, `redirect_valid` is 1 and `redirect_pc` = {vector base bits 31:16, offset register of the granted type bits 15:4, 4'b0000}.
- R5: Bits 15:0 of the vector base register (SPR 6) always read 0, and writes to them are ignored. Offset registers read 0 in bits 31:16 and in bits 3:0, whatever was written there.
- R6: Offset register n sits at SPR 32+n. Offset registers exist only for n in {0..6, 8, 10..15, 32..35}. Any other n reads 0 and ignores writes. The type code on a request lane selects offset register n = type.
- R7: A granted interrupt of type 2, 3, 5, 6, 13, 14, 32, 33 or 34 loads the syndrome register (SPR 5) with `syn_bits` on the next clock. Every other type leaves it unchanged; this includes type 1 (machine check).
- R8: A granted interrupt of type 2, 5 or 13 loads the fault-address register (SPR 4) with `fault_addr` on the next clock. Every other type leaves it unchanged.
- R9: When there is no ack, `rfci` drives `redirect_pc` = SPR 2 and `msr_restore` = SPR 3, with `redirect_valid` and `msr_restore_valid` both 1. If `rfci` is low, `rfi` does the same from SPR 0 and SPR 1. An ack in the same cycle overrides both strobes, and `msr_restore_valid` stays 0.
- R10: `spr_rdata` shows the register at `spr_addr` in the same cycle. A write with `spr_we` takes effect on the next clock. If an interrupt capture hits the same register in the same cycle, the captured value wins.
- R11: After reset, every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Noncritical-class interrupt request, held until acknowledged |
| irq_type | input | 6 | Type code of the noncritical request |
| cirq_req | input | 1 | Critical-class interrupt request |
| cirq_type | input | 6 | Type code of the critical request (0, 12 or 15) |
| cur_pc | input | 32 | Current or next instruction address to save |
| cur_msr | input | 32 | Current machine state word to save |
| fault_addr | input | 32 | Data address referenced by the faulting access |
| syn_bits | input | 32 | Syndrome bits for the exception being raised |
| rfi | input | 1 | Return-from-noncritical strobe |
| rfci | input | 1 | Return-from-critical strobe |
| spr_we | input | 1 | Special-register write enable |
| spr_addr | input | 7 | Special-register number |
| spr_wdata | input | 32 | Special-register write data |
| spr_rdata | output | 32 | Special-register read data |
| irq_ack | output | 1 | Noncritical request granted this cycle |
| cirq_ack | output | 1 | Critical request granted this cycle |
| redirect_valid | output | 1 | Redirect target valid |
| redirect_pc | output | 32 | Handler address or return address |
| msr_restore_valid | output | 1 | Restored state word valid |
| msr_restore | output | 32 | State word to restore |

## Verification
The assertions assume that the critical lane carries only types 0, 12 and 15, and that the noncritical lane carries only the other defined types. Lane and class therefore agree, and the pair chosen by lane is the pair chosen by class. They also assume that a request type always has a defined offset register. The stimulus draws every request type from those two per-lane lists, so an undefined type code never appears. It reaches undefined offset registers only through the special-register port, where R6 defines what happens.

// File: rtl/intv_pkg.sv
package intv_pkg;
  localparam int XLEN      = 32;
  localparam int TYPE_W    = 6;
  localparam int NUM_VEC   = 36;
  localparam int IVOR_BASE = 32;
  localparam int SPR_AW    = 7;
  localparam int OFF_LSB   = 4;

  typedef logic [TYPE_W-1:0] itype_t;

  // special-register numbers of the scalar registers
  localparam logic [SPR_AW-1:0] SPR_SAVE_PC  = 7'd0;
  localparam logic [SPR_AW-1:0] SPR_SAVE_ST  = 7'd1;
  localparam logic [SPR_AW-1:0] SPR_CSAVE_PC = 7'd2;
  localparam logic [SPR_AW-1:0] SPR_CSAVE_ST = 7'd3;
  localparam logic [SPR_AW-1:0] SPR_FADDR    = 7'd4;
  localparam logic [SPR_AW-1:0] SPR_SYND     = 7'd5;
  localparam logic [SPR_AW-1:0] SPR_VBASE    = 7'd6;

  function automatic logic vec_defined(itype_t t);
    return (t <= 6) || (t == 8) || (t >= 10 && t <= 15) || (t >= 32 && t <= 35);
  endfunction

  function automatic logic is_critical(itype_t t);
    return (t == 0) || (t == 12) || (t == 15);
  endfunction

  function automatic logic loads_syndrome(itype_t t);
    return t inside {6'd2, 6'd3, 6'd5, 6'd6, 6'd13, 6'd14, 6'd32, 6'd33, 6'd34};
  endfunction

  function automatic logic loads_fault_addr(itype_t t);
    return t inside {6'd2, 6'd5, 6'd13};
  endfunction

  function automatic logic [XLEN-1:0] handler_addr(logic [XLEN/2-1:0] prefix,
                                                   logic [XLEN/2-OFF_LSB-1:0] off);
    return {prefix, off, {OFF_LSB{1'b0}}};
  endfunction
endpackage

// File: rtl/intv_save_pair.sv
module intv_save_pair
  import intv_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         save,
  input  logic [W-1:0] save_pc,
  input  logic [W-1:0] save_msr,
  input  logic         wr_pc,
  input  logic         wr_msr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pc_q,
  output logic [W-1:0] msr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      msr_q <= '0;
    end else if (save) begin
      pc_q  <= save_pc;
      msr_q <= save_msr;
    end else begin
      if (wr_pc)  pc_q  <= wdata;
      if (wr_msr) msr_q <= wdata;
    end
  end

  AST_PAIR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    save |=> (pc_q == $past(save_pc)) && (msr_q == $past(save_msr))); // R1
  AST_PAIR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!save && !wr_pc && !wr_msr) |=> $stable(pc_q) && $stable(msr_q)); // R2
endmodule

// File: rtl/intv_vector_table.sv
module intv_vector_table
  import intv_pkg::*;
#(
  parameter int W       = XLEN,
  parameter int TW      = TYPE_W,
  parameter int NV      = NUM_VEC,
  parameter int ALIGN_B = OFF_LSB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_we,
  input  logic          off_we,
  input  logic [TW-1:0] off_widx,
  input  logic [W-1:0]  wdata,
  input  logic [TW-1:0] hidx,
  input  logic [TW-1:0] ridx,
  output logic [W-1:0]  base_q,
  output logic [W-1:0]  handler,
  output logic [W-1:0]  off_rd
);
  localparam int HALF  = W / 2;
  localparam int OFF_W = HALF - ALIGN_B;

  logic [HALF-1:0]  prefix_q;
  logic [OFF_W-1:0] off_q [NV];
  logic [OFF_W-1:0] h_off, r_off;

  always_ff @(posedge clk) begin
    if (!rst_n)       prefix_q <= '0;
    else if (base_we) prefix_q <= wdata[W-1:HALF];
  end

  for (genvar g = 0; g < NV; g++) begin : g_off
    if (vec_defined(itype_t'(g))) begin : g_real
      always_ff @(posedge clk) begin
        if (!rst_n) off_q[g] <= '0;
        else if (off_we && off_widx == TW'(g)) off_q[g] <= wdata[HALF-1:ALIGN_B];
      end
    end else begin : g_hole
      assign off_q[g] = '0;
    end
  end

  assign h_off   = (int'(hidx) < NV) ? off_q[hidx] : '0;
  assign r_off   = (int'(ridx) < NV) ? off_q[ridx] : '0;
  assign base_q  = {prefix_q, {HALF{1'b0}}};
  assign handler = handler_addr(prefix_q, h_off);
  assign off_rd  = {{HALF{1'b0}}, r_off, {ALIGN_B{1'b0}}};

  AST_BASE_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    base_we |=> base_q[HALF-1:0] == '0); // R5
  AST_BASE_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    base_we |=> base_q[W-1:HALF] == $past(wdata[W-1:HALF])); // R10
endmodule

// File: rtl/intr_vector_unit.sv
module intr_vector_unit
  import intv_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int TW = TYPE_W,
  parameter int NV = NUM_VEC,
  parameter int AW = SPR_AW,
  parameter int VB = IVOR_BASE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_req,
  input  logic [TW-1:0] irq_type,
  input  logic          cirq_req,
  input  logic [TW-1:0] cirq_type,
  input  logic [W-1:0]  cur_pc,
  input  logic [W-1:0]  cur_msr,
  input  logic [W-1:0]  fault_addr,
  input  logic [W-1:0]  syn_bits,
  input  logic          rfi,
  input  logic          rfci,
  input  logic          spr_we,
  input  logic [AW-1:0] spr_addr,
  input  logic [W-1:0]  spr_wdata,
  output logic [W-1:0]  spr_rdata,
  output logic          irq_ack,
  output logic          cirq_ack,
  output logic          redirect_valid,
  output logic [W-1:0]  redirect_pc,
  output logic          msr_restore_valid,
  output logic [W-1:0]  msr_restore
);
  // named internal events
  logic          take_crit, take_nc, take_any, ret_crit, ret_nc;
  logic [TW-1:0] take_type;
  logic          vec_sel;
  logic [TW-1:0] vec_idx;
  logic [W-1:0]  pair_pc [2];
  logic [W-1:0]  pair_st [2];
  logic [W-1:0]  synd_q, faddr_q, base_q, handler, off_rd;

  assign take_crit = cirq_req;
  assign take_nc   = irq_req && !cirq_req;
  assign take_any  = take_crit || take_nc;
  assign take_type = take_crit ? cirq_type : irq_type;
  assign ret_crit  = !take_any && rfci;
  assign ret_nc    = !take_any && rfi && !rfci;

  assign vec_sel = (int'(spr_addr) >= VB) && (int'(spr_addr) < VB + NV);
  assign vec_idx = TW'(int'(spr_addr) - VB);

  // pair 0 noncritical, pair 1 critical
  for (genvar g = 0; g < 2; g++) begin : g_pair
    intv_save_pair #(.W(W)) u_pair (
      .clk     (clk),
      .rst_n   (rst_n),
      .save    ((g == 1) ? take_crit : take_nc),
      .save_pc (cur_pc),
      .save_msr(cur_msr),
      .wr_pc   (spr_we && spr_addr == AW'(2 * g)),
      .wr_msr  (spr_we && spr_addr == AW'(2 * g + 1)),
      .wdata   (spr_wdata),
      .pc_q    (pair_pc[g]),
      .msr_q   (pair_st[g])
    );
  end

  intv_vector_table #(.W(W), .TW(TW), .NV(NV), .ALIGN_B(OFF_LSB)) u_vec (
    .clk     (clk),
    .rst_n   (rst_n),
    .base_we (spr_we && spr_addr == SPR_VBASE),
    .off_we  (spr_we && vec_sel),
    .off_widx(vec_idx),
    .wdata   (spr_wdata),
    .hidx    (take_type),
    .ridx    (vec_idx),
    .base_q  (base_q),
    .handler (handler),
    .off_rd  (off_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      synd_q  <= '0;
      faddr_q <= '0;
    end else begin
      if (take_any && loads_syndrome(take_type)) synd_q <= syn_bits;
      else if (spr_we && spr_addr == SPR_SYND)   synd_q <= spr_wdata;
      if (take_any && loads_fault_addr(take_type)) faddr_q <= fault_addr;
      else if (spr_we && spr_addr == SPR_FADDR)    faddr_q <= spr_wdata;
    end
  end

  always_comb begin
    if (vec_sel) spr_rdata = off_rd;
    else begin
      case (spr_addr)
        SPR_SAVE_PC:  spr_rdata = pair_pc[0];
        SPR_SAVE_ST:  spr_rdata = pair_st[0];
        SPR_CSAVE_PC: spr_rdata = pair_pc[1];
        SPR_CSAVE_ST: spr_rdata = pair_st[1];
        SPR_FADDR:    spr_rdata = faddr_q;
        SPR_SYND:     spr_rdata = synd_q;
        SPR_VBASE:    spr_rdata = base_q;
        default:      spr_rdata = '0;
      endcase
    end
  end

  assign irq_ack           = take_nc;
  assign cirq_ack          = take_crit;
  assign redirect_valid    = take_any || ret_crit || ret_nc;
  assign redirect_pc       = take_any ? handler : (ret_crit ? pair_pc[1] : pair_pc[0]);
  assign msr_restore_valid = ret_crit || ret_nc;
  assign msr_restore       = ret_crit ? pair_st[1] : pair_st[0];

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_ack, cirq_ack})); // R3
  AST_LANE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    cirq_req |-> is_critical(cirq_type)); // R3
  AST_CRIT_SPARES_NC: assert property (@(posedge clk) disable iff (!rst_n)
    (cirq_ack && !(spr_we && spr_addr < AW'(2))) |=> $stable(pair_pc[0]) && $stable(pair_st[0])); // R2
  AST_SYND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (take_any && !loads_syndrome(take_type) && !(spr_we && spr_addr == SPR_SYND)) |=> $stable(synd_q)); // R7
  AST_FADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (take_any && !loads_fault_addr(take_type) && !(spr_we && spr_addr == SPR_FADDR)) |=> $stable(faddr_q)); // R8
  AST_GRANT_NO_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack || cirq_ack) |-> redirect_valid && !msr_restore_valid); // R9
  AST_HANDLER_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack || cirq_ack) |-> redirect_pc[OFF_LSB-1:0] == '0); // R4
endmodule

// File: tb/intr_vector_unit_test.sv
`timescale 1ns/1ps
module intr_vector_unit_test;
  logic        clk = 0, rst_n = 0;
  logic        irq_req, cirq_req, rfi, rfci, spr_we;
  logic [5:0]  irq_type, cirq_type;
  logic [31:0] cur_pc, cur_msr, fault_addr, syn_bits, spr_wdata;
  logic [6:0]  spr_addr;
  logic [31:0] spr_rdata, redirect_pc, msr_restore;
  logic        irq_ack, cirq_ack, redirect_valid, msr_restore_valid;

  intr_vector_unit uut (.*);

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // behavioural reference state
  logic [31:0] m_pair [4];
  logic [31:0] m_faddr, m_synd, m_base;
  logic [31:0] m_off [64];

  function automatic bit has_vec(int n);
    int ok[$] = '{0,1,2,3,4,5,6,8,10,11,12,13,14,15,32,33,34,35};
    foreach (ok[i]) if (ok[i] == n) return 1;
    return 0;
  endfunction
  function automatic bit syn_type(int n);
    return n == 2 || n == 3 || n == 5 || n == 6 || n == 13 || n == 14 || n == 32 || n == 33 || n == 34;
  endfunction
  function automatic bit dear_type(int n);
    return n == 2 || n == 5 || n == 13;
  endfunction
  function automatic logic [31:0] m_read(int a);
    if (a < 4) return m_pair[a];
    if (a == 4) return m_faddr;
    if (a == 5) return m_synd;
    if (a == 6) return m_base;
    if (a >= 32 && a < 96 && has_vec(a - 32)) return m_off[a - 32];
    return 0;
  endfunction
  function automatic logic [31:0] m_handler(int t);
    return (m_base & 32'hFFFF0000) | m_off[t];
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    irq_req = 0; cirq_req = 0; rfi = 0; rfci = 0; spr_we = 0;
    irq_type = 0; cirq_type = 0; cur_pc = 0; cur_msr = 0;
    fault_addr = 0; syn_bits = 0; spr_addr = 0; spr_wdata = 0;
  endtask

  task automatic step(input string tag);
    logic e_ack, e_cack, e_rv, e_mv;
    logic [31:0] e_pc, e_msr;
    int t;
    #1;
    e_cack = cirq_req;
    e_ack  = irq_req && !cirq_req;
    e_mv = 0; e_msr = 0; e_rv = 0; e_pc = 0;
    if (e_cack)      begin e_rv = 1; e_pc = m_handler(cirq_type); end
    else if (e_ack)  begin e_rv = 1; e_pc = m_handler(irq_type); end
    else if (rfci)   begin e_rv = 1; e_mv = 1; e_pc = m_pair[2]; e_msr = m_pair[3]; end
    else if (rfi)    begin e_rv = 1; e_mv = 1; e_pc = m_pair[0]; e_msr = m_pair[1]; end
    chk(tag, "cirq_ack", 32'(cirq_ack), 32'(e_cack));
    chk(tag, "irq_ack", 32'(irq_ack), 32'(e_ack));
    chk(tag, "redirect_valid", 32'(redirect_valid), 32'(e_rv));
    chk(tag, "msr_restore_valid", 32'(msr_restore_valid), 32'(e_mv));
    if (e_rv) chk(tag, "redirect_pc", redirect_pc, e_pc);
    if (e_mv) chk(tag, "msr_restore", msr_restore, e_msr);
    chk(tag, $sformatf("spr_rdata[%0d]", spr_addr), spr_rdata, m_read(int'(spr_addr)));
    @(posedge clk);
    if (spr_we) begin
      t = int'(spr_addr);
      if (t < 4) m_pair[t] = spr_wdata;
      else if (t == 4) m_faddr = spr_wdata;
      else if (t == 5) m_synd = spr_wdata;
      else if (t == 6) m_base = spr_wdata & 32'hFFFF0000;
      else if (t >= 32 && has_vec(t - 32)) m_off[t - 32] = spr_wdata & 32'h0000FFF0;
    end
    if (e_cack || e_ack) begin
      t = e_cack ? int'(cirq_type) : int'(irq_type);
      if (e_cack) begin m_pair[2] = cur_pc; m_pair[3] = cur_msr; end
      else        begin m_pair[0] = cur_pc; m_pair[1] = cur_msr; end
      if (syn_type(t))  m_synd = syn_bits;
      if (dear_type(t)) m_faddr = fault_addr;
    end
    @(negedge clk);
    idle();
  endtask

  task automatic rd(input string tag, input int a);
    spr_addr = 7'(a); step(tag);
  endtask
  task automatic wr(input string tag, input int a, input logic [31:0] d);
    spr_we = 1; spr_addr = 7'(a); spr_wdata = d; step(tag);
  endtask
  task automatic nc_irq(input string tag, input int t, input logic [31:0] pc);
    irq_req = 1; irq_type = 6'(t); cur_pc = pc; cur_msr = pc ^ 32'h5A5A0000;
    fault_addr = pc + 32'h00F0_0000; syn_bits = 32'h1 << (t % 32);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    int ncl[$] = '{1,2,3,4,5,6,8,10,11,13,14,32,33,34,35};
    int crl[$] = '{0,12,15};
    int vl[$]  = '{0,1,2,3,4,5,6,8,10,11,12,13,14,15,32,33,34,35};
    foreach (m_pair[i]) m_pair[i] = 0;
    foreach (m_off[i]) m_off[i] = 0;
    m_faddr = 0; m_synd = 0; m_base = 0;
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    for (int a = 0; a < 7; a++) rd("R11", a);
    rd("R11", 32); rd("R11", 67);

    wr("R5", 6, 32'hFFF0_ABCD);
    rd("R5", 6);
    foreach (vl[i]) wr("R6", 32 + vl[i], 32'hBEEF_0007 + 32'(vl[i]) * 32'h0000_0130);
    foreach (vl[i]) rd("R5", 32 + vl[i]);
    wr("R6", 39, 32'h1234_5678); rd("R6", 39);
    wr("R6", 48, 32'h1234_5678); rd("R6", 48);

    foreach (ncl[i]) begin
      nc_irq("R4", ncl[i], 32'h0001_0000 + 32'(ncl[i]) * 4);
      step("R4");
      rd("R1", 0); rd("R1", 1); rd("R7", 5); rd("R8", 4); rd("R1", 2);
    end
    nc_irq("R7", 2, 32'h0000_2200); step("R7");
    nc_irq("R7", 1, 32'h0000_3300); syn_bits = 32'hFFFF_FFFF; step("R7");
    rd("R7", 5); rd("R8", 4);

    foreach (crl[i]) begin
      cirq_req = 1; cirq_type = 6'(crl[i]); cur_pc = 32'h0008_0000 + 32'(crl[i]);
      cur_msr = 32'hC000_0000 | 32'(crl[i]); syn_bits = 32'hAAAA_5555; fault_addr = 32'h7777_7777;
      step("R2");
      rd("R2", 2); rd("R2", 3); rd("R2", 0); rd("R2", 1); rd("R7", 5); rd("R8", 4);
    end

    nc_irq("R3", 5, 32'h0000_4400);
    cirq_req = 1; cirq_type = 6'd12; step("R3");
    nc_irq("R3", 5, 32'h0000_4400); step("R3");
    rd("R3", 0); rd("R3", 2); rd("R8", 4);

    rfi = 1; step("R9");
    rfci = 1; step("R9");
    rfi = 1; rfci = 1; step("R9");
    nc_irq("R9", 8, 32'h0000_5500); rfi = 1; step("R9");
    cirq_req = 1; cirq_type = 6'd15; cur_pc = 32'h0000_6600; rfci = 1; step("R9");
    rfi = 1; step("R9"); rfci = 1; step("R9");

    wr("R10", 0, 32'hDEAD_0000);
    nc_irq("R10", 4, 32'h0000_7700); spr_we = 1; spr_addr = 7'd0; spr_wdata = 32'h1111_1111; step("R10");
    rd("R10", 0);
    nc_irq("R10", 10, 32'h0000_7800); spr_we = 1; spr_addr = 7'd5; spr_wdata = 32'h2222_2222; step("R10");
    rd("R10", 5);
    nc_irq("R10", 13, 32'h0000_7900); spr_we = 1; spr_addr = 7'd4; spr_wdata = 32'h3333_3333; step("R10");
    rd("R10", 4);
    wr("R10", 3, 32'h4444_4444); rfci = 1; step("R9");

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R9 watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule